// File: doc/BRIEF.md
# Receive Descriptor Status Writer

This block keeps the receive side of a packet engine in step with a ring of buffer descriptors held in memory. For every frame that the receive path announces, it checks that the descriptor under the ring pointer is free. It counts the frame bytes into fixed-size buffers and closes one descriptor each time a buffer fills. When the frame ends, it composes the 16-bit status word that the engine must write back. The descriptor memory stays outside the block. The block presents the index it is looking at, reads back that descriptor's current word, and emits one write-back strobe with index and word for each descriptor it closes.

The status word is numbered from the most significant end, so descriptor bit n is vector bit 15-n. The block composes the error and address flags from several sources: the first six frame bytes (the destination address), the running byte count, the end-of-frame results from the receive path, and the configuration inputs for promiscuous reception and maximum length. A strict priority applies to these flags. A FIFO overrun silences the miss, length, alignment and CRC flags. An alignment error silences the CRC flag. Frames longer than 2047 bytes are cut off. Software regains a descriptor by setting its empty bit again. The wrap bit of a descriptor sends the ring pointer back to the configured base index.

Top module: `rxbd_status_writer`

## Requirements
- R1: After reset, desc_idx equals cfg_ring_base, and wb_valid and no_buf are 0.
- R2: Every written-back word has bit 15 (empty) at 0. Bits 13 (wrap), 14 and 12 (software bits) are copied from the descriptor as read. Bits 10, 9 and 3 are 0. Bit 11 (last) is 1 on the descriptor that closes the frame. The software bits have no effect on behaviour.
- R3: The write-back strobe lasts one cycle for each closed descriptor, in the cycle after the closing event. At that point desc_idx has moved to cfg_ring_base if the closed word has bit 13 set, and to the next index (modulo the ring size) if it does not.
- R4: On the last descriptor, bit 7 is set when all six destination bytes are FF. Bit 6 is set when the first destination byte has bit 0 set and the address is not broadcast. Frames shorter than six bytes set neither bit.
- R5: Bit 8 (miss) is set only when cfg_promisc is 1 and rx_addr_hit is 0 at frame end, with no overrun.
- R6: Bit 5 (long) is set when the accepted length exceeds cfg_max_len, or when the frame was truncated, with no overrun.
- R7: Bit 4 (non-octet) is set when rx_dribble and rx_crc_bad are both 1. Bit 2 (CRC) is set when rx_crc_bad is 1 and rx_dribble is 0. Both bits are 0 under overrun.
- R8: Bit 1 (overrun) follows rx_overrun, and when it is set, bits 8, 5, 4 and 2 are 0.
- R9: Bytes beyond 2047 are not accepted: they fill no further buffer. Such a frame sets bit 0 (truncated) and bit 5.
- R10: After BUF_BYTES bytes in one buffer, the next accepted byte closes that descriptor with last at 0 and bits 0 to 2 and 4 to 8 at 0. The frame then continues in the next descriptor.
- R11: If the descriptor under the pointer has empty at 0 when a frame starts, no_buf pulses one cycle later. The frame produces no write-back, and desc_idx is unchanged.
- R12: If the descriptor reached by chaining has empty at 0, no_buf pulses. The rest of the frame is dropped with no further write-back, and desc_idx stays on that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_promisc | input | 1 | Accept frames that missed the address filter |
| cfg_max_len | input | LEN_W | Length above which the long flag is set |
| cfg_ring_base | input | IDX_W | Ring base index, used after reset and on wrap |
| rx_start | input | 1 | Frame begins (no byte in this cycle) |
| rx_byte_vld | input | 1 | A frame byte is present |
| rx_byte | input | 8 | Frame byte, destination address first |
| rx_end | input | 1 | Frame ends; the result inputs below are valid |
| rx_dribble | input | 1 | Frame bit count is not a multiple of eight |
| rx_crc_bad | input | 1 | CRC check failed |
| rx_overrun | input | 1 | Receive FIFO overran during the frame |
| rx_addr_hit | input | 1 | Address filter matched |
| desc_idx | output | IDX_W | Index of the current descriptor |
| desc_word | input | 16 | Current contents of descriptor desc_idx |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | IDX_W | Index to write back |
| wb_word | output | 16 | Status word to write back |
| no_buf | output | 1 | Pulse: frame dropped for lack of a free descriptor |

## Verification
A wrong ring pointer shows up right away: the next write-back carries the wrong index, and the pointer check after each frame fails. A buffer or byte counter that drifts changes how many descriptors a frame closes. The first misplaced intermediate strobe or missing final strobe then exposes it, even before the status bits are compared. A wrong state-machine state or pending-check flag shows up as a missing or extra no_buf pulse, or as write-backs during a dropped frame, within a few cycles of the frame end.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

   localparam int unsigned BD_W = 16;

   // descriptor bit n (numbered from the MSB) sits at vector position BD_W-1-n
   localparam int unsigned B_EMPTY  = BD_W - 1 - 0;
   localparam int unsigned B_SWA    = BD_W - 1 - 1;
   localparam int unsigned B_WRAP   = BD_W - 1 - 2;
   localparam int unsigned B_SWB    = BD_W - 1 - 3;
   localparam int unsigned B_LAST   = BD_W - 1 - 4;
   localparam int unsigned B_MISS   = BD_W - 1 - 7;
   localparam int unsigned B_BCAST  = BD_W - 1 - 8;
   localparam int unsigned B_MCAST  = BD_W - 1 - 9;
   localparam int unsigned B_LONG   = BD_W - 1 - 10;
   localparam int unsigned B_NONOCT = BD_W - 1 - 11;
   localparam int unsigned B_CRC    = BD_W - 1 - 13;
   localparam int unsigned B_OVR    = BD_W - 1 - 14;
   localparam int unsigned B_TRUNC  = BD_W - 1 - 15;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_RECV = 2'd1,
      RX_DROP = 2'd2
   } rx_state_e;

   typedef struct packed {
      logic last;
      logic miss;
      logic bcast;
      logic mcast;
      logic too_long;
      logic non_oct;
      logic crc_bad;
      logic ovr;
      logic trunc;
   } bd_flags_t;

endpackage

// File: rtl/rxbd_da_classify.sv
module rxbd_da_classify #(
   parameter int unsigned DA_BYTES = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       byte_vld,
   input  logic [7:0] byte_d,
   output logic       is_bcast,
   output logic       is_mcast
);
   localparam int unsigned CNT_W = $clog2(DA_BYTES + 1);

   if (DA_BYTES < 1) begin : g_bad_da
      $error("rxbd_da_classify: DA_BYTES must be at least 1");
   end

   logic [CNT_W-1:0]    seen_q;
   logic [DA_BYTES-1:0] ones_w;
   logic                group_q;
   logic                take;
   logic                full;

   assign take = byte_vld && (seen_q != CNT_W'(DA_BYTES));
   assign full = (seen_q == CNT_W'(DA_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         seen_q  <= '0;
         group_q <= 1'b0;
      end else if (take) begin
         seen_q <= seen_q + 1'b1;
         if (seen_q == '0) group_q <= byte_d[0];
      end
   end

   for (genvar i = 0; i < DA_BYTES; i++) begin : g_byte
      logic all_ones_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            all_ones_q <= 1'b0;
         else if (take && (seen_q == CNT_W'(i)))
            all_ones_q <= (byte_d == 8'hFF);
      end
      assign ones_w[i] = all_ones_q;
   end

   assign is_bcast = full && (&ones_w);
   assign is_mcast = full && group_q && !(&ones_w);

endmodule

// File: rtl/rxbd_len_track.sv
module rxbd_len_track #(
   parameter int unsigned LEN_W     = 11,
   parameter int unsigned BUF_BYTES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             byte_vld,
   output logic [LEN_W-1:0] frame_len,
   output logic             trunc,
   output logic             chain_now
);
   localparam int unsigned LEN_MAX = (1 << LEN_W) - 1;
   localparam int unsigned BUF_W   = $clog2(BUF_BYTES + 1);

   if (LEN_W < 4 || LEN_W > 16) begin : g_bad_len
      $error("rxbd_len_track: LEN_W out of range 4..16");
   end
   if (BUF_BYTES < 1 || BUF_BYTES > LEN_MAX) begin : g_bad_buf
      $error("rxbd_len_track: BUF_BYTES must lie in 1..2**LEN_W-1");
   end

   logic [LEN_W-1:0] len_q;
   logic [BUF_W-1:0] buf_q;
   logic             trunc_q;
   logic             at_limit;
   logic             accept;

   assign at_limit  = (len_q == LEN_W'(LEN_MAX));
   assign accept    = byte_vld && !at_limit;
   assign chain_now = accept && (buf_q == BUF_W'(BUF_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         len_q   <= '0;
         buf_q   <= '0;
         trunc_q <= 1'b0;
      end else begin
         if (accept) begin
            len_q <= len_q + 1'b1;
            buf_q <= chain_now ? BUF_W'(1) : buf_q + 1'b1;
         end
         if (byte_vld && at_limit) trunc_q <= 1'b1;
      end
   end

   assign frame_len = len_q;
   assign trunc     = trunc_q;

endmodule

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr #(
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] base,
   input  logic             advance,
   input  logic             wrap,
   output logic [IDX_W-1:0] idx
);
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("rxbd_ring_ptr: IDX_W out of range 1..12");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= base;
      else if (advance)
         idx <= wrap ? base : idx + 1'b1;
   end

endmodule

// File: rtl/rxbd_status_pack.sv
module rxbd_status_pack
   import rxbd_pkg::*;
(
   input  logic [BD_W-1:0] desc_word,
   input  logic            last,
   input  logic            promisc,
   input  logic            addr_hit,
   input  logic            bcast,
   input  logic            mcast,
   input  logic            too_long,
   input  logic            dribble,
   input  logic            crc_bad,
   input  logic            ovr,
   input  logic            trunc,
   output logic [BD_W-1:0] word
);
   bd_flags_t fl;

   always_comb begin
      fl          = '0;
      fl.last     = last;
      if (last) begin
         fl.ovr      = ovr;
         fl.trunc    = trunc;
         fl.bcast    = bcast;
         fl.mcast    = mcast;
         fl.miss     = promisc && !addr_hit && !ovr;
         fl.too_long = too_long && !ovr;
         fl.non_oct  = dribble && crc_bad && !ovr;
         fl.crc_bad  = crc_bad && !dribble && !ovr;
      end
   end

   always_comb begin
      word           = '0;
      word[B_EMPTY]  = 1'b0;
      word[B_SWA]    = desc_word[B_SWA];
      word[B_SWB]    = desc_word[B_SWB];
      word[B_WRAP]   = desc_word[B_WRAP];
      word[B_LAST]   = fl.last;
      word[B_MISS]   = fl.miss;
      word[B_BCAST]  = fl.bcast;
      word[B_MCAST]  = fl.mcast;
      word[B_LONG]   = fl.too_long;
      word[B_NONOCT] = fl.non_oct;
      word[B_CRC]    = fl.crc_bad;
      word[B_OVR]    = fl.ovr;
      word[B_TRUNC]  = fl.trunc;
   end

endmodule

// File: rtl/rxbd_status_writer.sv
module rxbd_status_writer
   import rxbd_pkg::*;
#(
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned LEN_W     = 11,
   parameter int unsigned BUF_BYTES = 64,
   parameter int unsigned DA_BYTES  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_promisc,
   input  logic [LEN_W-1:0] cfg_max_len,
   input  logic [IDX_W-1:0] cfg_ring_base,
   input  logic             rx_start,
   input  logic             rx_byte_vld,
   input  logic [7:0]       rx_byte,
   input  logic             rx_end,
   input  logic             rx_dribble,
   input  logic             rx_crc_bad,
   input  logic             rx_overrun,
   input  logic             rx_addr_hit,
   output logic [IDX_W-1:0] desc_idx,
   input  logic [BD_W-1:0]  desc_word,
   output logic             wb_valid,
   output logic [IDX_W-1:0] wb_idx,
   output logic [BD_W-1:0]  wb_word,
   output logic             no_buf
);
   rx_state_e        st_q, st_d;
   logic             pend_q, pend_d;
   logic             clr_frame;
   logic             recv_ok;
   logic             byte_take;
   logic             fire;
   logic             close_last;
   logic             nobuf_d;
   logic             chain_now;
   logic             trunc;
   logic             is_bcast, is_mcast;
   logic [LEN_W-1:0] frame_len;
   logic [BD_W-1:0]  pack_word;

   // a freshly chained descriptor is verified one cycle after the pointer moved
   assign recv_ok   = (st_q == RX_RECV) && !(pend_q && !desc_word[B_EMPTY]);
   assign byte_take = recv_ok && !rx_end && rx_byte_vld;

   always_comb begin
      st_d       = st_q;
      pend_d     = pend_q;
      clr_frame  = 1'b0;
      fire       = 1'b0;
      close_last = 1'b0;
      nobuf_d    = 1'b0;
      unique case (st_q)
         RX_IDLE: begin
            if (rx_start) begin
               if (desc_word[B_EMPTY]) begin
                  st_d      = RX_RECV;
                  pend_d    = 1'b0;
                  clr_frame = 1'b1;
               end else begin
                  st_d    = RX_DROP;
                  nobuf_d = 1'b1;
               end
            end
         end
         RX_RECV: begin
            if (!recv_ok) begin
               nobuf_d = 1'b1;
               pend_d  = 1'b0;
               st_d    = rx_end ? RX_IDLE : RX_DROP;
            end else begin
               pend_d = 1'b0;
               if (rx_end) begin
                  fire       = 1'b1;
                  close_last = 1'b1;
                  st_d       = RX_IDLE;
               end else if (chain_now) begin
                  fire   = 1'b1;
                  pend_d = 1'b1;
               end
            end
         end
         RX_DROP: begin
            if (rx_end) st_d = RX_IDLE;
         end
         default: st_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         pend_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
      end
   end

   rxbd_da_classify #(
      .DA_BYTES (DA_BYTES)
   ) u_da (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_frame),
      .byte_vld (byte_take),
      .byte_d   (rx_byte),
      .is_bcast (is_bcast),
      .is_mcast (is_mcast)
   );

   rxbd_len_track #(
      .LEN_W     (LEN_W),
      .BUF_BYTES (BUF_BYTES)
   ) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_frame),
      .byte_vld  (byte_take),
      .frame_len (frame_len),
      .trunc     (trunc),
      .chain_now (chain_now)
   );

   rxbd_ring_ptr #(
      .IDX_W (IDX_W)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .base    (cfg_ring_base),
      .advance (fire),
      .wrap    (desc_word[B_WRAP]),
      .idx     (desc_idx)
   );

   rxbd_status_pack u_pack (
      .desc_word (desc_word),
      .last      (close_last),
      .promisc   (cfg_promisc),
      .addr_hit  (rx_addr_hit),
      .bcast     (is_bcast),
      .mcast     (is_mcast),
      .too_long  ((frame_len > cfg_max_len) || trunc),
      .dribble   (rx_dribble),
      .crc_bad   (rx_crc_bad),
      .ovr       (rx_overrun),
      .trunc     (trunc),
      .word      (pack_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_idx   <= '0;
         wb_word  <= '0;
         no_buf   <= 1'b0;
      end else begin
         wb_valid <= fire;
         no_buf   <= nobuf_d;
         if (fire) begin
            wb_idx  <= desc_idx;
            wb_word <= pack_word;
         end
      end
   end

endmodule

// File: rtl/rxbd_status_writer_chk.sv
module rxbd_status_writer_chk
   import rxbd_pkg::*;
#(
   parameter int unsigned IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_promisc,
   input logic [IDX_W-1:0] cfg_ring_base,
   input logic             rx_addr_hit,
   input logic [IDX_W-1:0] desc_idx,
   input logic             wb_valid,
   input logic [IDX_W-1:0] wb_idx,
   input logic [BD_W-1:0]  wb_word,
   input logic             no_buf
);

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!wb_valid && !no_buf));

   p_empty_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !wb_word[B_EMPTY]);

   p_wrap_to_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_word[B_WRAP]) |-> (desc_idx == $past(cfg_ring_base)));

   p_step_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_word[B_WRAP] && !$past(wb_valid)) |-> (desc_idx == IDX_W'(wb_idx + 1'b1)));

   p_bc_mc_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !(wb_word[B_BCAST] && wb_word[B_MCAST]));

   p_miss_needs_prom_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_word[B_MISS]) |-> ($past(cfg_promisc) && !$past(rx_addr_hit)));

   p_no_hides_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_word[B_NONOCT]) |-> !wb_word[B_CRC]);

   p_ovr_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_word[B_OVR]) |->
         !(wb_word[B_MISS] || wb_word[B_LONG] || wb_word[B_NONOCT] || wb_word[B_CRC]));

   p_trunc_is_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_word[B_TRUNC]) |-> wb_word[B_LONG]);

   p_mid_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_word[B_LAST]) |->
         ($countones({wb_word[B_MISS], wb_word[B_BCAST], wb_word[B_MCAST], wb_word[B_LONG],
                      wb_word[B_NONOCT], wb_word[B_CRC], wb_word[B_OVR], wb_word[B_TRUNC]}) == 0));

   p_nobuf_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      no_buf |-> !wb_valid);

endmodule

bind rxbd_status_writer rxbd_status_writer_chk #(
   .IDX_W (IDX_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_promisc   (cfg_promisc),
   .cfg_ring_base (cfg_ring_base),
   .rx_addr_hit   (rx_addr_hit),
   .desc_idx      (desc_idx),
   .wb_valid      (wb_valid),
   .wb_idx        (wb_idx),
   .wb_word       (wb_word),
   .no_buf        (no_buf)
);

// File: tb/rxbd_status_writer_test.sv
module rxbd_status_writer_test;
   localparam int IDX_W = 4;
   localparam int LEN_W = 11;
   localparam int BUFB  = 16;
   localparam int NDESC = 1 << IDX_W;
   localparam int LIMIT = 2047;
   localparam logic [IDX_W-1:0] BASE = 4'd2;
   localparam int WRAP_AT = 9;

   // expected bit positions (descriptor bit n at vector 15-n)
   localparam int X_E = 15, X_SA = 14, X_W = 13, X_SB = 12, X_L = 11;
   localparam int X_M = 8, X_BC = 7, X_MC = 6, X_LG = 5, X_NO = 4;
   localparam int X_CR = 2, X_OV = 1, X_TR = 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_promisc = 1'b0;
   logic [LEN_W-1:0] cfg_max_len = 11'd1518;
   logic [IDX_W-1:0] cfg_ring_base = BASE;
   logic rx_start = 0, rx_byte_vld = 0, rx_end = 0;
   logic [7:0] rx_byte = 0;
   logic rx_dribble = 0, rx_crc_bad = 0, rx_overrun = 0, rx_addr_hit = 0;
   logic [IDX_W-1:0] desc_idx, wb_idx;
   logic [15:0] desc_word, wb_word;
   logic wb_valid, no_buf;

   logic [15:0] mem [NDESC];
   logic [15:0] exp_mem [NDESC];
   logic [IDX_W+15:0] exp_q [$];
   int n_checks = 0, n_errors = 0;
   int exp_nobuf = 0, seen_nobuf = 0;
   logic [IDX_W-1:0] mp;
   bit auto_rearm = 1'b0;
   string cur_tag = "R1";

   assign desc_word = mem[desc_idx];

   always #5 clk = ~clk;

   rxbd_status_writer #(.IDX_W(IDX_W), .LEN_W(LEN_W), .BUF_BYTES(BUFB)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_promisc(cfg_promisc), .cfg_max_len(cfg_max_len),
      .cfg_ring_base(cfg_ring_base), .rx_start(rx_start), .rx_byte_vld(rx_byte_vld),
      .rx_byte(rx_byte), .rx_end(rx_end), .rx_dribble(rx_dribble), .rx_crc_bad(rx_crc_bad),
      .rx_overrun(rx_overrun), .rx_addr_hit(rx_addr_hit), .desc_idx(desc_idx),
      .desc_word(desc_word), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_word(wb_word),
      .no_buf(no_buf));

   task automatic check(input string tag, input bit ok, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [IDX_W-1:0] next_of(input logic [IDX_W-1:0] p);
      return exp_mem[p][X_W] ? BASE : IDX_W'(p + 1);
   endfunction

   function automatic logic [15:0] compose(input logic [15:0] d, input bit last,
      input bit bc, input bit mc, input bit lg, input bit drib, input bit crc,
      input bit ov, input bit tr, input bit hit);
      logic [15:0] w = '0;
      w[X_W] = d[X_W]; w[X_SA] = d[X_SA]; w[X_SB] = d[X_SB];
      if (last) begin
         w[X_L]  = 1'b1;
         w[X_BC] = bc; w[X_MC] = mc; w[X_OV] = ov; w[X_TR] = tr;
         w[X_M]  = cfg_promisc && !hit && !ov;
         w[X_LG] = lg && !ov;
         w[X_NO] = drib && crc && !ov;
         w[X_CR] = crc && !drib && !ov;
      end
      return w;
   endfunction

   // frame-level reference: fills the expected write queue and moves the model pointer
   task automatic predict(input int n, input logic [47:0] da, input bit drib,
                          input bit crc, input bit ov, input bit hit);
      int acc, nb;
      bit tr, bc, mc, lg;
      logic [15:0] w;
      if (!exp_mem[mp][X_E]) begin
         exp_nobuf++;
         return;
      end
      acc = (n > LIMIT) ? LIMIT : n;
      tr  = (n > LIMIT);
      nb  = (acc == 0) ? 1 : (acc + BUFB - 1) / BUFB;
      bc  = (n >= 6) && (da == 48'hFFFF_FFFF_FFFF);
      mc  = (n >= 6) && da[40] && !bc;
      lg  = (acc > int'(cfg_max_len)) || tr;
      for (int k = 0; k < nb; k++) begin
         if (k > 0 && !exp_mem[mp][X_E]) begin
            exp_nobuf++;
            return;
         end
         w = compose(exp_mem[mp], k == nb - 1, bc, mc, lg, drib, crc, ov, tr, hit);
         exp_q.push_back({mp, w});
         exp_mem[mp] = auto_rearm ? (w | 16'h8000) : w;
         mp = next_of(mp);
      end
   endtask

   task automatic send_frame(input int n, input logic [47:0] da, input bit drib,
                             input bit crc, input bit ov, input bit hit, input string tag);
      cur_tag = tag;
      predict(n, da, drib, crc, ov, hit);
      @(negedge clk) rx_start = 1'b1;
      @(negedge clk) rx_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         rx_byte_vld = 1'b1;
         rx_byte = (i < 6) ? da[47 - 8*i -: 8] : 8'($urandom);
         @(negedge clk);
      end
      rx_byte_vld = 1'b0;
      rx_end = 1'b1; rx_dribble = drib; rx_crc_bad = crc; rx_overrun = ov; rx_addr_hit = hit;
      @(negedge clk);
      rx_end = 1'b0; rx_dribble = 0; rx_crc_bad = 0; rx_overrun = 0; rx_addr_hit = 0;
      repeat (4) @(negedge clk);
      check(tag, exp_q.size() == 0, "missing write-backs", exp_q.size(), 0);
      check(tag, seen_nobuf == exp_nobuf, "no_buf pulses", seen_nobuf, exp_nobuf);
      check(tag, desc_idx == mp, "ring pointer", desc_idx, mp);
      exp_q.delete();
   endtask

   task automatic rearm_all();
      for (int i = 0; i < NDESC; i++) begin
         mem[i][X_E] = 1'b1;
         exp_mem[i][X_E] = 1'b1;
      end
   endtask

   // write-back monitor acting as the memory side
   always @(negedge clk) begin
      if (rst_n) begin
         if (no_buf) seen_nobuf++;
         if (wb_valid) begin
            if (exp_q.size() == 0) begin
               check(cur_tag, 1'b0, "unexpected write-back", {wb_idx, wb_word}, 0);
            end else begin
               logic [IDX_W+15:0] e;
               e = exp_q.pop_front();
               check(cur_tag, wb_idx == e[IDX_W+15:16], "write-back index", wb_idx, e[IDX_W+15:16]);
               check(cur_tag, wb_word == e[15:0], "status word", wb_word, e[15:0]);
            end
            mem[wb_idx] = auto_rearm ? (wb_word | 16'h8000) : wb_word;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      logic [47:0] da;
      int unsigned seed;
      seed = $urandom(32'd4242);
      for (int i = 0; i < NDESC; i++) begin
         // junk in reserved and flag positions must not reach the write-back (R2)
         mem[i] = 16'($urandom) | 16'h8000;
         mem[i][X_W] = (i == WRAP_AT);
         exp_mem[i] = mem[i];
      end
      mp = BASE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", desc_idx == BASE, "reset pointer", desc_idx, BASE);
      check("R1", wb_valid == 1'b0, "reset wb_valid", wb_valid, 0);
      check("R1", no_buf == 1'b0, "reset no_buf", no_buf, 0);

      // directed cases, descriptors re-armed by hand
      send_frame(12, 48'hFFFF_FFFF_FFFF, 0, 0, 0, 1, "R4");
      send_frame(10, 48'h0100_5E00_0001, 0, 0, 0, 0, "R4");
      send_frame(3,  48'hFFFF_FF00_0000, 0, 0, 0, 1, "R4");
      cfg_promisc = 1'b1;
      send_frame(14, 48'h0200_0000_0005, 0, 0, 0, 0, "R5");
      send_frame(14, 48'h0200_0000_0005, 0, 0, 0, 1, "R5");
      cfg_promisc = 1'b0;
      send_frame(14, 48'h0200_0000_0005, 0, 0, 0, 0, "R5");
      rearm_all();
      send_frame(9,  48'h0200_0000_0007, 1, 1, 0, 1, "R7");
      send_frame(9,  48'h0200_0000_0007, 0, 1, 0, 1, "R7");
      send_frame(9,  48'h0200_0000_0007, 1, 0, 0, 1, "R7");
      cfg_max_len = 11'd40;
      send_frame(45, 48'h0200_0000_0009, 0, 0, 0, 1, "R6");
      send_frame(32, 48'h0200_0000_0009, 0, 0, 0, 1, "R10");
      rearm_all();
      cfg_promisc = 1'b1;
      send_frame(50, 48'h0100_0000_0009, 1, 1, 1, 0, "R8");
      send_frame(0,  48'h0, 0, 0, 0, 1, "R2");

      // no buffer at frame start
      rearm_all();
      mem[mp][X_E] = 1'b0; exp_mem[mp][X_E] = 1'b0;
      send_frame(20, 48'h0200_0000_0001, 0, 0, 0, 1, "R11");
      // no buffer after chaining
      rearm_all();
      mem[next_of(mp)][X_E] = 1'b0; exp_mem[next_of(mp)][X_E] = 1'b0;
      send_frame(40, 48'h0200_0000_0001, 0, 0, 0, 1, "R12");
      rearm_all();

      // truncation with software refilling every descriptor at once
      auto_rearm = 1'b1;
      send_frame(2100, 48'hFFFF_FFFF_FFFF, 0, 0, 0, 1, "R9");
      send_frame(2047, 48'h0200_0000_0003, 0, 1, 0, 1, "R9");
      send_frame(20, 48'h0200_0000_0003, 0, 0, 0, 1, "R3");

      // randomised traffic
      for (int f = 0; f < 40; f++) begin
         int t;
         t = int'($urandom % 3);
         if (t == 0) da = 48'hFFFF_FFFF_FFFF;
         else if (t == 1) da = {8'($urandom) | 8'h01, 8'h00, 32'($urandom)};
         else da = {8'($urandom) & 8'hFE, 40'($urandom)};
         cfg_promisc = 1'($urandom);
         cfg_max_len = 11'(20 + $urandom % 50);
         send_frame(int'($urandom % 70), da, ($urandom % 4) == 0, ($urandom % 3) == 0,
                    ($urandom % 5) == 0, ($urandom % 2) == 0, "R3");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule